// File: doc/BRIEF.md
# Operand Effective Address Unit

This unit turns the operand fields of an 8-bit CPU instruction into a 16-bit data memory address and then carries out the memory access that the instruction needs. It supports four ways of forming the address: a fixed zero page addressed by the operand byte, an index register plus a signed 8-bit displacement, a pointer register taken as it is, and a register-bank slot in a fixed page. The slot is formed from the bank pointer and the opcode's low three bits.

After the address is formed, the unit drives a synchronous byte-wide memory port. It does a single byte read or write, a two-byte word read or write in big-endian order, or a bit set or bit clear. A bit set or bit clear reads the byte and writes it back with a single bit changed. Requests arrive through a valid/ready handshake that the unit accepts only when idle. A one-cycle done pulse reports completion and carries the assembled read data.

The sequencer has eight states. IDLE waits for a request. RD_A presents the first read address. RD_B presents the second address of a word read and captures the high byte. RD_LAT captures the last read byte. MOD_WR writes back the modified byte of a bit operation. WR_A writes the first byte. WR_B writes the second byte of a word write. FIN raises done. The transitions are as follows:
- IDLE goes to RD_A for reads and bit operations, and to WR_A for writes.
- RD_A goes to RD_B for a word read, to MOD_WR for a bit operation, and to RD_LAT otherwise.
- RD_B goes to RD_LAT.
- WR_A goes to WR_B for a word write and to FIN otherwise.
- RD_LAT, MOD_WR and WR_B each go to FIN.
- FIN goes to IDLE.

Top module: `opaddr_unit`

## Requirements
- R1: With `req_mode`=0 (zero page), the first address presented is {0x00, `req_operand`}.
- R2: With `req_mode`=1 (indexed), the first address is `req_ix` plus `req_operand` sign-extended to 16 bits, modulo 65536.
- R3: With `req_mode`=2 (pointer), the first address is `req_ep` unchanged.
- R4: With `req_mode`=3 (register bank), the first address is {0x01, `req_rp[4:0]`, `req_opc_lo[2:0]`}.
- R5: A word read (`req_op`=2) reads the address A and then A+1 modulo 65536. It returns `rdata` = {byte at A, byte at A+1}.
- R6: A word write (`req_op`=3) writes `req_wdata[15:8]` to A in one cycle and `req_wdata[7:0]` to A+1 in the next cycle.
- R7: A bit set (`req_op`=4) or bit clear (`req_op`=5) first reads A. In the next cycle it writes A with only bit `req_opc_lo` forced to 1 or to 0. It returns the original byte in `rdata[7:0]`.
- R8: `req_ready` is high only when idle, and a request is taken on a clock edge where both valid and ready are high. Counting the accepting edge, `done` rises after this many edges: 3 for a byte read, 4 for a word read, 2 for a byte write, 3 for a word write and 3 for a bit operation. `done` stays high for exactly one cycle.
- R9: A byte read (`req_op`=0, and also the unused codes 6 and 7) returns {0x00, byte}. A write returns `rdata`=0.
- R10: During reset and right after it, `req_ready` is 1, `done` is 0 and `mem_we` is 0.
- R11: `mem_we` is high only in write cycles. It is never high while the unit is idle or in a read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_mode | input | 2 | Address mode: 0 zero page, 1 indexed, 2 pointer, 3 register bank |
| req_op | input | 3 | Access: 0 byte read, 1 byte write, 2 word read, 3 word write, 4 bit set, 5 bit clear |
| req_opc_lo | input | 3 | Opcode low bits: register slot or bit position |
| req_operand | input | 8 | Operand byte (page offset or displacement) |
| req_ix | input | 16 | Index register value |
| req_ep | input | 16 | Pointer register value |
| req_rp | input | 5 | Register bank pointer |
| req_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid one cycle after the address with we low |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result, valid while done is high |

## Verification
The hardest situations to reach are the wrap-arounds: the second byte of a word access falling from 0xFFFF to 0x0000, and an indexed sum crossing the top or bottom of the space. The stimulus reaches them with a pointer of 0xFFFF, an index of 0xFFF0 with a positive displacement, and an index of 0x0003 with a displacement of 0x80. The bit write-back is also hard to see from outside. To observe it, the bench first places a known byte with a byte write. It then sets or clears one bit and reads the byte back, with one case where the bit already has the target value.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

    typedef enum logic [1:0] {
        AM_ZPAGE   = 2'd0,
        AM_INDEXED = 2'd1,
        AM_POINTER = 2'd2,
        AM_REGBANK = 2'd3
    } amode_e;

    typedef enum logic [2:0] {
        OP_RD_BYTE = 3'd0,
        OP_WR_BYTE = 3'd1,
        OP_RD_WORD = 3'd2,
        OP_WR_WORD = 3'd3,
        OP_BIT_SET = 3'd4,
        OP_BIT_CLR = 3'd5
    } acc_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_A,
        S_RD_B,
        S_RD_LAT,
        S_MOD_WR,
        S_WR_A,
        S_WR_B,
        S_FIN
    } seq_state_e;

endpackage

// File: rtl/opaddr_ea_gen.sv
module opaddr_ea_gen
    import opaddr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int RP_W   = 5,
    parameter int SEL_W  = 3,
    parameter logic [ADDR_W-DATA_W-1:0] ZPAGE_HI = '0,
    parameter logic [ADDR_W-DATA_W-1:0] RBANK_HI = 1
) (
    input  logic [1:0]        mode,
    input  logic [SEL_W-1:0]  opc_lo,
    input  logic [DATA_W-1:0] operand,
    input  logic [ADDR_W-1:0] ix,
    input  logic [ADDR_W-1:0] ep,
    input  logic [RP_W-1:0]   rp,
    output logic [ADDR_W-1:0] ea
);
    localparam int HI_W = ADDR_W - DATA_W;

    logic [ADDR_W-1:0] disp_ext;
    logic [DATA_W-1:0] slot_lo;

    assign disp_ext = {{HI_W{operand[DATA_W-1]}}, operand};
    assign slot_lo  = DATA_W'({rp, opc_lo});

    always_comb begin
        unique case (mode)
            AM_ZPAGE:   ea = {ZPAGE_HI, operand};
            AM_INDEXED: ea = ix + disp_ext;
            AM_POINTER: ea = ep;
            AM_REGBANK: ea = {RBANK_HI, slot_lo};
            default:    ea = ep;
        endcase
    end
endmodule

// File: rtl/opaddr_bit_mod.sv
module opaddr_bit_mod #(
    parameter int DATA_W = 8,
    localparam int POS_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din,
    input  logic [POS_W-1:0]  pos,
    input  logic              set_val,
    output logic [DATA_W-1:0] dout
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign dout[i] = (pos == POS_W'(i)) ? set_val : din[i];
    end
endmodule

// File: rtl/opaddr_seq.sv
module opaddr_seq
    import opaddr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int SEL_W  = 3,
    localparam int WORD_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [SEL_W-1:0]  req_opc_lo,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [ADDR_W-1:0] ea_in,
    input  logic [DATA_W-1:0] mod_byte,
    output logic [SEL_W-1:0]  bit_pos,
    output logic              bit_val,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic [WORD_W-1:0] rdata
);
    seq_state_e        state, state_nx;
    logic [ADDR_W-1:0] ea_q;
    logic [2:0]        op_q;
    logic [SEL_W-1:0]  pos_q;
    logic [WORD_W-1:0] wdata_q;
    logic [WORD_W-1:0] rd_q;
    logic              accept;
    logic              is_bit_op;

    assign accept    = req_valid && (state == S_IDLE);
    assign is_bit_op = (op_q == OP_BIT_SET) || (op_q == OP_BIT_CLR);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (req_valid) begin
                    if (req_op == OP_WR_BYTE || req_op == OP_WR_WORD) state_nx = S_WR_A;
                    else                                                 state_nx = S_RD_A;
                end
            end
            S_RD_A: begin
                if (op_q == OP_RD_WORD) state_nx = S_RD_B;
                else if (is_bit_op)     state_nx = S_MOD_WR;
                else                    state_nx = S_RD_LAT;
            end
            S_RD_B:   state_nx = S_RD_LAT;
            S_RD_LAT: state_nx = S_FIN;
            S_MOD_WR: state_nx = S_FIN;
            S_WR_A:   state_nx = (op_q == OP_WR_WORD) ? S_WR_B : S_FIN;
            S_WR_B:   state_nx = S_FIN;
            S_FIN:    state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // request capture and read assembly
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q    <= '0;
            op_q    <= '0;
            pos_q   <= '0;
            wdata_q <= '0;
            rd_q    <= '0;
        end else begin
            if (accept) begin
                ea_q    <= ea_in;
                op_q    <= req_op;
                pos_q   <= req_opc_lo;
                wdata_q <= req_wdata;
                rd_q    <= '0;
            end
            if (state == S_RD_B)                         rd_q[WORD_W-1:DATA_W] <= mem_rdata;
            if (state == S_RD_LAT || state == S_MOD_WR)  rd_q[DATA_W-1:0]      <= mem_rdata;
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        done      = 1'b0;
        mem_addr  = ea_q;
        mem_we    = 1'b0;
        mem_wdata = wdata_q[DATA_W-1:0];
        unique case (state)
            S_IDLE:   req_ready = 1'b1;
            S_RD_A:   mem_addr  = ea_q;
            S_RD_B:   mem_addr  = ea_q + ADDR_W'(1);
            S_RD_LAT: mem_addr  = ea_q;
            S_MOD_WR: begin
                mem_we    = 1'b1;
                mem_wdata = mod_byte;
            end
            S_WR_A: begin
                mem_we    = 1'b1;
                mem_wdata = (op_q == OP_WR_WORD) ? wdata_q[WORD_W-1:DATA_W]
                                                 : wdata_q[DATA_W-1:0];
            end
            S_WR_B: begin
                mem_we    = 1'b1;
                mem_addr  = ea_q + ADDR_W'(1);
                mem_wdata = wdata_q[DATA_W-1:0];
            end
            S_FIN:    done = 1'b1;
            default:  req_ready = 1'b0;
        endcase
    end

    assign rdata   = rd_q;
    assign bit_pos = pos_q;
    assign bit_val = (op_q == OP_BIT_SET);
endmodule

// File: rtl/opaddr_unit.sv
module opaddr_unit
    import opaddr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int RP_W   = 5,
    parameter int SEL_W  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [1:0]          req_mode,
    input  logic [2:0]          req_op,
    input  logic [SEL_W-1:0]    req_opc_lo,
    input  logic [DATA_W-1:0]   req_operand,
    input  logic [ADDR_W-1:0]   req_ix,
    input  logic [ADDR_W-1:0]   req_ep,
    input  logic [RP_W-1:0]     req_rp,
    input  logic [2*DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_we,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                done,
    output logic [2*DATA_W-1:0] rdata
);
    logic [ADDR_W-1:0] ea;
    logic [DATA_W-1:0] mod_byte;
    logic [SEL_W-1:0]  bit_pos;
    logic              bit_val;

    opaddr_ea_gen #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RP_W(RP_W), .SEL_W(SEL_W)
    ) u_ea (
        .mode(req_mode), .opc_lo(req_opc_lo), .operand(req_operand),
        .ix(req_ix), .ep(req_ep), .rp(req_rp), .ea(ea)
    );

    opaddr_bit_mod #(.DATA_W(DATA_W)) u_bit (
        .din(mem_rdata), .pos(bit_pos), .set_val(bit_val), .dout(mod_byte)
    );

    opaddr_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_opc_lo(req_opc_lo), .req_wdata(req_wdata),
        .ea_in(ea), .mod_byte(mod_byte),
        .bit_pos(bit_pos), .bit_val(bit_val),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .done(done), .rdata(rdata)
    );
endmodule

// File: rtl/opaddr_unit_chk.sv
module opaddr_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [1:0]  req_mode,
    input logic [2:0]  req_opc_lo,
    input logic [7:0]  req_operand,
    input logic [15:0] req_ix,
    input logic [15:0] req_ep,
    input logic [4:0]  req_rp,
    input logic [15:0] mem_addr,
    input logic        mem_we,
    input logic [7:0]  mem_wdata,
    input logic [7:0]  mem_rdata,
    input logic        done
);
    logic take;
    assign take = req_valid && req_ready;

    p_zpage_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        take && req_mode == 2'd0 |=> mem_addr == {8'h00, $past(req_operand)});

    p_index_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take && req_mode == 2'd1 |=>
        mem_addr == $past(req_ix) + {{8{$past(req_operand[7])}}, $past(req_operand)});

    p_pointer_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take && req_mode == 2'd2 |=> mem_addr == $past(req_ep));

    p_regbank_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take && req_mode == 2'd3 |=> mem_addr == {8'h01, $past(req_rp), $past(req_opc_lo)});

    p_word_next_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && $past(mem_we) |-> mem_addr == $past(mem_addr) + 16'd1);

    p_rmw_one_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && !$past(mem_we) && !$past(req_ready) |->
        ($countones(mem_wdata ^ mem_rdata) <= 1) && mem_addr == $past(mem_addr));

    p_busy_after_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !req_ready);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && req_ready);

    p_we_not_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !req_ready && !done);
endmodule

bind opaddr_unit opaddr_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_opc_lo(req_opc_lo), .req_operand(req_operand),
    .req_ix(req_ix), .req_ep(req_ep), .req_rp(req_rp),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .done(done)
);

// File: tb/sim_opaddr_unit.sv
`timescale 1ns/1ps
module sim_opaddr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_mode = '0;
    logic [2:0]  req_op = '0;
    logic [2:0]  req_opc_lo = '0;
    logic [7:0]  req_operand = '0;
    logic [15:0] req_ix = '0;
    logic [15:0] req_ep = '0;
    logic [4:0]  req_rp = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        done;
    logic [15:0] rdata;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    opaddr_unit u0 (.*);

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ {a[9:8], 6'h2D};
    endfunction

    logic [7:0] mem [1024];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) mem[i] <= pat(16'(i));
        end else begin
            if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
            mem_rdata <= mem[mem_addr[9:0]];
        end
    end

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    logic [15:0] r_rd, r_a0, r_a1;
    logic        r_we0, r_we1, r_rdy1;
    logic [7:0]  r_wd0, r_wd1;
    int          r_lat;

    task automatic run(input logic [1:0] mode, input logic [2:0] op, input logic [2:0] opc,
                       input logic [7:0] operand, input logic [15:0] ix, input logic [15:0] ep,
                       input logic [4:0] rp, input logic [15:0] wd);
        @(negedge clk);
        req_mode = mode; req_op = op; req_opc_lo = opc; req_operand = operand;
        req_ix = ix; req_ep = ep; req_rp = rp; req_wdata = wd; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        r_lat = 1;
        r_a0 = mem_addr; r_we0 = mem_we; r_wd0 = mem_wdata; r_rdy1 = req_ready;
        r_a1 = '0; r_we1 = 1'b0; r_wd1 = '0;
        while (!done && r_lat < 20) begin
            @(negedge clk);
            r_lat++;
            if (r_lat == 2) begin
                r_a1 = mem_addr; r_we1 = mem_we; r_wd1 = mem_wdata;
            end
        end
        r_rd = rdata;
    endtask

    // mode, op, opc, operand, ix, ep, rp, expected first address
    localparam logic [68:0] VEC [0:8] = '{
        {2'd0, 3'd0, 3'd2, 8'h34, 16'h0000, 16'h0000, 5'd0,  16'h0034},
        {2'd0, 3'd0, 3'd7, 8'hFF, 16'h1111, 16'h2222, 5'd3,  16'h00FF},
        {2'd1, 3'd0, 3'd0, 8'h05, 16'h27A0, 16'h0000, 5'd0,  16'h27A5},
        {2'd1, 3'd0, 3'd0, 8'hFF, 16'h2800, 16'h0000, 5'd0,  16'h27FF},
        {2'd1, 3'd6, 3'd0, 8'h80, 16'h0003, 16'h0000, 5'd0,  16'hFF83},
        {2'd1, 3'd0, 3'd0, 8'h20, 16'hFFF0, 16'h0000, 5'd0,  16'h0010},
        {2'd2, 3'd0, 3'd0, 8'h99, 16'h0000, 16'h27A5, 5'd0,  16'h27A5},
        {2'd3, 3'd0, 3'd7, 8'h00, 16'h0000, 16'h0000, 5'h1F, 16'h01FF},
        {2'd3, 3'd7, 3'd5, 8'h00, 16'h0000, 16'h0000, 5'h02, 16'h0115}
    };

    task automatic summary;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        // R10 reset state
        repeat (3) @(negedge clk);
        chk("R10 ready in reset", {15'd0, req_ready}, 16'd1);
        chk("R10 done in reset",  {15'd0, done},      16'd0);
        chk("R10 we in reset",    {15'd0, mem_we},    16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 ready after reset", {15'd0, req_ready}, 16'd1);

        foreach (VEC[k]) begin
            automatic logic [68:0] v = VEC[k];
            automatic string tag;
            case (v[68:67])
                2'd0: tag = "R1 zero page";
                2'd1: tag = "R2 indexed";
                2'd2: tag = "R3 pointer";
                default: tag = "R4 register bank";
            endcase
            run(v[68:67], v[66:64], v[63:61], v[60:53], v[52:37], v[36:21], v[20:16], 16'h0);
            chk(tag, r_a0, v[15:0]);
            chk("R9 byte read data", r_rd, {8'h00, pat(v[15:0])});
            chk("R8 byte read latency", 16'(r_lat), 16'd3);
            chk("R11 no write on read", {15'd0, r_we0 | r_we1}, 16'd0);
        end

        // R5 word read, normal and wrapping
        run(2'd2, 3'd2, 3'd0, 8'h00, 16'h0, 16'h27A5, 5'd0, 16'h0);
        chk("R5 word addr hi", r_a0, 16'h27A5);
        chk("R5 word addr lo", r_a1, 16'h27A6);
        chk("R5 word data", r_rd, {pat(16'h27A5), pat(16'h27A6)});
        chk("R8 word read latency", 16'(r_lat), 16'd4);
        chk("R8 busy not ready", {15'd0, r_rdy1}, 16'd0);
        @(negedge clk);
        chk("R8 done one cycle", {15'd0, done}, 16'd0);
        chk("R8 ready after done", {15'd0, req_ready}, 16'd1);

        run(2'd2, 3'd2, 3'd0, 8'h00, 16'h0, 16'hFFFF, 5'd0, 16'h0);
        chk("R5 wrap addr", r_a1, 16'h0000);
        chk("R5 wrap data", r_rd, {pat(16'hFFFF), pat(16'h0000)});

        // R6 word write, then read back
        run(2'd2, 3'd3, 3'd0, 8'h00, 16'h0, 16'h27A5, 5'd0, 16'h1234);
        chk("R6 first write byte", {8'h00, r_wd0}, 16'h0012);
        chk("R6 second write byte", {8'h00, r_wd1}, 16'h0034);
        chk("R6 second addr", r_a1, 16'h27A6);
        chk("R6 both cycles write", {14'd0, r_we0, r_we1}, 16'd3);
        chk("R8 word write latency", 16'(r_lat), 16'd3);
        chk("R9 write rdata zero", r_rd, 16'h0000);
        run(2'd2, 3'd0, 3'd0, 8'h00, 16'h0, 16'h27A5, 5'd0, 16'h0);
        chk("R6 readback hi", r_rd, 16'h0012);
        run(2'd2, 3'd0, 3'd0, 8'h00, 16'h0, 16'h27A6, 5'd0, 16'h0);
        chk("R6 readback lo", r_rd, 16'h0034);

        // R4/R9 byte write through register bank
        run(2'd3, 3'd1, 3'd5, 8'h00, 16'h0, 16'h0, 5'h02, 16'hAA5C);
        chk("R4 write addr", r_a0, 16'h0115);
        chk("R8 byte write latency", 16'(r_lat), 16'd2);
        chk("R9 byte write rdata", r_rd, 16'h0000);
        run(2'd3, 3'd0, 3'd5, 8'h00, 16'h0, 16'h0, 5'h02, 16'h0);
        chk("R4 byte write readback", r_rd, 16'h005C);

        // R7 bit set on a cleared byte
        run(2'd0, 3'd1, 3'd0, 8'h40, 16'h0, 16'h0, 5'd0, 16'h0000);
        run(2'd0, 3'd4, 3'd3, 8'h40, 16'h0, 16'h0, 5'd0, 16'h0);
        chk("R7 set returns original", r_rd, 16'h0000);
        chk("R7 read then write", {14'd0, r_we0, r_we1}, 16'd1);
        chk("R7 write same addr", r_a1, 16'h0040);
        chk("R8 bit op latency", 16'(r_lat), 16'd3);
        run(2'd0, 3'd0, 3'd0, 8'h40, 16'h0, 16'h0, 5'd0, 16'h0);
        chk("R7 set result", r_rd, 16'h0008);

        // R7 bit clear, and clear of an already-clear bit
        run(2'd0, 3'd1, 3'd0, 8'h41, 16'h0, 16'h0, 5'd0, 16'h00FF);
        run(2'd0, 3'd5, 3'd0, 8'h41, 16'h0, 16'h0, 5'd0, 16'h0);
        chk("R7 clear returns original", r_rd, 16'h00FF);
        run(2'd0, 3'd0, 3'd0, 8'h41, 16'h0, 16'h0, 5'd0, 16'h0);
        chk("R7 clear result", r_rd, 16'h00FE);
        run(2'd0, 3'd5, 3'd0, 8'h41, 16'h0, 16'h0, 5'd0, 16'h0);
        run(2'd0, 3'd0, 3'd0, 8'h41, 16'h0, 16'h0, 5'd0, 16'h0);
        chk("R7 clear idempotent", r_rd, 16'h00FE);

        summary();
    end
endmodule